// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte-Lane Writes

This block models a clocked static memory of 36-bit words built from four 9-bit byte lanes. The address, the write data and every control input except the output enable are sampled on the rising clock edge. Either of two address strobes opens a burst. One strobe is intended for a processor and the other for a cache controller. After the first access, the two low address bits come from an internal 2-bit counter. The counter moves only in cycles where the advance input is low, and it follows a linear or an interleaved order. The order is chosen by a mode input that is captured together with the address.

Reads are flow-through. The registered address indexes the array combinationally, so the word appears on `dout` in the cycle that follows the capturing edge, with no output register stage. Writes happen at the clock edge, either per byte lane or to all lanes at once.

A small state machine tracks the device mode, with three states:
- `ST_DESEL`: deselected, outputs off, writes ignored.
- `ST_READ`: selected, output driven when enabled.
- `ST_WRITE`: selected, the last edge wrote the array, output off.

Its transitions are:
- A strobe with all three chip enables asserted goes to `ST_READ`. It goes to `ST_WRITE` instead when the controller-side strobe is used and a write is requested.
- A strobe with any chip enable deasserted goes to `ST_DESEL`.
- With no strobe, `ST_DESEL` stays in `ST_DESEL`.
- With no strobe, `ST_READ` and `ST_WRITE` move to `ST_WRITE` when a write is requested, and to `ST_READ` otherwise.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and after its release, the block is deselected and `dout_en` is 0.
- R2: A rising edge with `adsp_n`=0 and all chip enables asserted (`ce1_n`=0, `ce2`=1, `ce3_n`=0) loads `addr_i`. From that edge, `dout` shows the stored word at that address and `dout_en` is 1 while `oe_n`=0.
- R3: A rising edge with `adsc_n`=0, all chip enables asserted and no write requested loads `addr_i` and reads it, in the same way as R2.
- R4: A burst started by `adsp_n` is a read even if `gw_n` or the byte writes are asserted in that cycle. The array is left unchanged.
- R5: With `lin_order`=1 captured at the start, each edge with `adv_n`=0 and no strobe adds 1 to the two low address bits, modulo 4. The upper address bits are kept.
- R6: With `lin_order`=0, the low bits of access k (k=0..3, counting advances) equal the start low bits XOR k.
- R7: An edge with `adv_n`=1 and no strobe keeps the current burst address.
- R8: In a selected cycle without a processor-side start, lane l is written exactly when `bwe_n`=0 and `bsel_n[l]`=0. The other lanes keep their contents. Lane a is bits 8:0, lane b is bits 17:9, lane c is bits 26:18 and lane d is bits 35:27. The write goes to the address that is current after the edge, and `dout_en` is 0 in the following cycle.
- R9: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bsel_n` are. `bwe_n`=0 together with `bsel_n`=4'b0000 also writes all four lanes.
- R10: A strobe with any chip enable deasserted deselects the device. While it is deselected, `dout_en` is 0 and write controls are ignored.
- R11: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R12: A strobe in the middle of a burst clears the counter and restarts the burst at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | AW | External word address |
| din_i | input | 36 | Write data, four 9-bit lanes |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low, bit l = lane l |
| gw_n | input | 1 | Global write, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 36 | Flow-through read data |
| dout_en | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The bench builds the block with `AW`=8, which gives a 256-word array. That size is small enough to fill through the ports with a global write to every address and to mirror in a reference array. With this size, bursts that start at each of the four low-bit offsets, in both orders, reach every wrap case of the 2-bit counter. The upper address bits are also checked to stay fixed during a burst. Directed cases then cover:
- lane-masked writes;
- deselection with ignored writes;
- the asynchronous output enable;
- a restart in the middle of a burst.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bsram_st_t;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] ext_addr_i,
    input  logic          lin_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] nxt_addr_o
);
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          lin_q;

    function automatic logic [AW-1:0] place(input logic [AW-1:0] b,
                                            input logic [1:0] c,
                                            input logic lin);
        logic [1:0] lo;
        lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
        return {b[AW-1:2], lo};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            lin_q  <= 1'b1;
        end else if (load_i) begin
            base_q <= ext_addr_i;
            cnt_q  <= 2'd0;
            lin_q  <= lin_i;
        end else if (step_i) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    always_comb begin
        addr_o = place(base_q, cnt_q, lin_q);
        if (load_i)
            nxt_addr_o = ext_addr_i;
        else
            nxt_addr_o = place(base_q, step_i ? cnt_q + 2'd1 : cnt_q, lin_q);
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(ext_addr_i)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(addr_o));
    p_lin_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && lin_q) |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));
    p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i) |=> (addr_o[AW-1:2] == $past(addr_o[AW-1:2])));
endmodule

// File: rtl/lane_write_dec.sv
module lane_write_dec
    import bsram_pkg::*;
(
    input  logic             wr_ok_i,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] lane_we_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_we_o[l] = wr_ok_i & (~gw_n | (~bwe_n & ~bsel_n[l]));
    end
endmodule

// File: rtl/sram_array.sv
module sram_array
    import bsram_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we_i[l])
                mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              gw_n,
    input  logic              lin_order,
    input  logic              oe_n,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    bsram_st_t         st_q, st_nxt;
    logic              strobe, en_all, wr_req, load, step;
    logic [AW-1:0]     cur_addr, nxt_addr;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] rdata;

    assign strobe = ~adsp_n | ~adsc_n;
    assign en_all = ~ce1_n & ce2 & ~ce3_n;
    assign wr_req = ~gw_n | (~bwe_n & ~(&bsel_n));
    assign load   = strobe & en_all;
    assign step   = ~strobe & ~adv_n & (st_q != ST_DESEL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_DESEL;
        else        st_q <= st_nxt;
    end

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        if (strobe) begin
            if (!en_all)                st_nxt = ST_DESEL;
            else if (!adsp_n || !wr_req) st_nxt = ST_READ;
            else                         st_nxt = ST_WRITE;
        end else begin
            unique case (st_q)
                ST_DESEL:          st_nxt = ST_DESEL;
                ST_READ, ST_WRITE: st_nxt = wr_req ? ST_WRITE : ST_READ;
                default:           st_nxt = ST_DESEL;
            endcase
        end
    end

    // outputs
    always_comb begin
        dout    = rdata;
        dout_en = (st_q == ST_READ) & ~oe_n;
    end

    burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .ext_addr_i (addr_i),
        .lin_i      (lin_order),
        .addr_o     (cur_addr),
        .nxt_addr_o (nxt_addr)
    );

    lane_write_dec u_dec (
        .wr_ok_i   (st_nxt == ST_WRITE),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bsel_n    (bsel_n),
        .lane_we_o (lane_we)
    );

    sram_array #(.AW(AW)) u_arr (
        .clk     (clk),
        .we_i    (lane_we),
        .waddr_i (nxt_addr),
        .wdata_i (din_i),
        .raddr_i (cur_addr),
        .rdata_o (rdata)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dout_en);
    p_adsp_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && en_all) |-> (lane_we == '0));
    p_gw_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_DESEL && !strobe && !gw_n) |-> (&lane_we));
    p_desel_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DESEL && !strobe) |-> (lane_we == '0));
    p_desel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DESEL) |-> !dout_en);
    p_oe_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);
endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int W  = 36;

    // {lin, use_adsp, start address, expected low-bit sequence k=0..3}
    localparam logic [17:0] TBL [8] = '{
        {1'b1, 1'b1, 8'h85, 8'b01_10_11_00},
        {1'b1, 1'b0, 8'h96, 8'b10_11_00_01},
        {1'b1, 1'b1, 8'hA7, 8'b11_00_01_10},
        {1'b1, 1'b0, 8'h38, 8'b00_01_10_11},
        {1'b0, 1'b1, 8'hC9, 8'b01_00_11_10},
        {1'b0, 1'b0, 8'h5E, 8'b10_11_00_01},
        {1'b0, 1'b1, 8'h7F, 8'b11_10_01_00},
        {1'b0, 1'b0, 8'hE4, 8'b00_01_10_11}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [W-1:0]  din_i = '0;
    logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic bwe_n = 1'b1, gw_n = 1'b1, lin_order = 1'b1, oe_n = 1'b0;
    logic [3:0] bsel_n = 4'hF;
    logic [W-1:0] dout;
    logic dout_en;

    logic [W-1:0] ref_m [256];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adsp_n(adsp_n),
        .adsc_n(adsc_n), .adv_n(adv_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
        .gw_n(gw_n), .lin_order(lin_order), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [W-1:0] pat(input logic [7:0] a);
        return {a, a ^ 8'h5A, 2'b10, a + 8'd3, 1'b1, ~a, 1'b0};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; bwe_n = 1'b1;
        bsel_n = 4'hF; gw_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        oe_n = 1'b0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_read(input logic [7:0] a, input string tag);
        check(dout_en === 1'b1 && dout === ref_m[a], tag, dout, ref_m[a]);
    endtask

    initial begin
        logic [W-1:0] m, d;
        idle();
        repeat (3) @(negedge clk);
        check(dout_en === 1'b0, "R1 in reset", {35'd0, dout_en}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_en === 1'b0, "R1 after reset", {35'd0, dout_en}, '0);

        // fill through the ports with global writes on controller strobe
        for (int a = 0; a < 256; a++) begin
            adsc_n = 1'b0; gw_n = 1'b0; addr_i = 8'(a); din_i = pat(8'(a));
            cyc();
            ref_m[a] = pat(8'(a));
        end
        idle();

        // table of bursts: R2/R3 start, R5 linear, R6 interleaved
        for (int i = 0; i < 8; i++) begin
            logic [7:0] sa;
            sa = TBL[i][15:8];
            lin_order = TBL[i][17];
            addr_i = sa;
            if (TBL[i][16]) adsp_n = 1'b0; else adsc_n = 1'b0;
            cyc();
            idle();
            expect_read({sa[7:2], TBL[i][7:6]}, TBL[i][16] ? "R2 start" : "R3 start");
            for (int k = 1; k < 4; k++) begin
                adv_n = 1'b0;
                cyc();
                expect_read({sa[7:2], TBL[i][7-2*k -: 2]},
                            TBL[i][17] ? "R5 linear step" : "R6 interleaved step");
            end
            adv_n = 1'b1;
        end

        // R7 hold
        lin_order = 1'b1; addr_i = 8'h41; adsc_n = 1'b0; cyc(); idle();
        adv_n = 1'b0; cyc(); adv_n = 1'b1;
        cyc(); cyc();
        expect_read(8'h42, "R7 hold");

        // R4 processor-side start ignores write controls
        addr_i = 8'h10; adsp_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'h0;
        din_i = '0;
        cyc(); idle();
        expect_read(8'h10, "R4 adsp stays read");
        // R8 lane write on following advance cycle: lanes a and c
        d = 36'h9_8765_4321;
        adv_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'b1010; din_i = d;
        cyc(); idle();
        check(dout_en === 1'b0, "R8 output off after write", {35'd0, dout_en}, '0);
        m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
        ref_m[8'h11] = (ref_m[8'h11] & ~m) | (d & m);
        addr_i = 8'h10; adsc_n = 1'b0; cyc(); idle();
        expect_read(8'h10, "R4 word unchanged");
        adv_n = 1'b0; cyc(); idle();
        expect_read(8'h11, "R8 lanes a,c written");

        // R9 all lanes via bwe with all selects, then via gw alone
        d = 36'hA_BCDE_F012;
        addr_i = 8'h20; adsc_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'h0; din_i = d;
        cyc(); idle(); ref_m[8'h20] = d;
        d = 36'h1_2233_4455;
        addr_i = 8'h21; adsc_n = 1'b0; gw_n = 1'b0; din_i = d;
        cyc(); idle(); ref_m[8'h21] = d;
        addr_i = 8'h20; adsc_n = 1'b0; cyc(); idle();
        expect_read(8'h20, "R9 all selects");
        adv_n = 1'b0; cyc(); idle();
        expect_read(8'h21, "R9 global write");

        // R8 selects without bwe do not write
        addr_i = 8'h22; adsc_n = 1'b0; bsel_n = 4'h0; din_i = '0;
        cyc(); idle();
        expect_read(8'h22, "R8 no bwe no write");

        // R10 deselect and ignored write
        addr_i = 8'h30; adsp_n = 1'b0; ce2 = 1'b0; cyc(); idle();
        check(dout_en === 1'b0, "R10 deselected", {35'd0, dout_en}, '0);
        gw_n = 1'b0; adv_n = 1'b0; din_i = '0; cyc(); idle();
        check(dout_en === 1'b0, "R10 still off", {35'd0, dout_en}, '0);
        addr_i = 8'h22; adsc_n = 1'b0; cyc(); idle();
        expect_read(8'h22, "R10 write ignored");
        adv_n = 1'b0; cyc(); idle();
        expect_read(8'h23, "R10 neighbour intact");

        // R11 asynchronous output enable
        #1 oe_n = 1'b1; #1;
        check(dout_en === 1'b0, "R11 oe off", {35'd0, dout_en}, '0);
        oe_n = 1'b0; #1;
        check(dout_en === 1'b1, "R11 oe on", {35'd0, dout_en}, 36'd1);

        // R12 restart mid-burst
        lin_order = 1'b1; addr_i = 8'h50; adsp_n = 1'b0; cyc(); idle();
        adv_n = 1'b0; cyc(); idle();
        expect_read(8'h51, "R12 before restart");
        lin_order = 1'b0; addr_i = 8'h6E; adsc_n = 1'b0; cyc(); idle();
        expect_read(8'h6E, "R12 new start");
        adv_n = 1'b0; cyc(); idle();
        expect_read(8'h6F, "R12 counter cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule